// File: doc/BRIEF.md
# Agent Mode and Clock Controller

This control-plane block keeps the operating mode of a small set of switch agents (ports or gateways) behind a 32-bit register bus. Software writes a requested mode code into an agent's control register. After a fixed transition latency, the reached mode shows in that agent's status register and on the `agent_mode` output. Software polls the status field to confirm the change.

The block also holds a shared clock-enable register: one global enable plus one enable per agent, and a write-one-to-clear disable register. A mode request sent to an agent that is not clocked is dropped. A reset-request register returns every agent to the reset mode. A trigger/ready handshake models the initialisation of a table RAM with a counter. Register reads are combinational. Writes take effect at the clock edge on which `wr_en` is sampled high.

Top module: `agent_mode_ctrl`

## Requirements
- R1: After reset, every agent mode is 0, no agent clock is enabled, the RAM-ready bit is 0, and every register reads 0.
- R2: The mode codes are reset=0, disable=1, config=2 and operation=3. A mode written to a clocked agent's control register (byte offset 0x10+8*i, bits 1:0) appears in its status register (0x14+8*i, bits 1:0) and on `agent_mode[2i+1:2i]` on the 8th clock edge after the write edge, and not before. The control register reads back the requested code.
- R3: The clock-enable register (0x04) stores a global enable in bit 16 and one enable per agent in bits N-1:0. `agent_clk_en[i]` is 1 only when both the agent bit and the global bit are set.
- R4: Each bit written as 1 to the clock-disable register (0x08) clears the matching per-agent enable bit. Bits written as 0 leave their enable bit unchanged. The clock-disable register reads 0.
- R5: A mode write to an agent whose `agent_clk_en` bit is 0 is ignored. Its control readback, its status and its mode output stay unchanged.
- R6: Writing 1 to bit 0 of the RAM-init register (0x0C) clears the ready bit (bit 1 of the same register). Ready reads 1 again on the 64th clock edge after the trigger edge.
- R7: While bit 0 of the reset-control register (0x00) is set, all agent modes, requests and pending transitions are cleared and mode writes are ignored. After the bit is cleared, all agents stay at mode 0.
- R8: Reads of unmapped offsets return 0, and writes to them change no register.
- R9: A second mode write to an agent during its transition replaces the pending code and restarts the 8-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| agent_clk_en | output | NUM_AGENTS | Effective per-agent clock enable |
| agent_mode | output | 2*NUM_AGENTS | Reached mode of each agent, 2 bits per agent |

## Verification
The bench samples each status one edge before and exactly on the 8th edge after a mode write. A design with an off-by-one latency therefore fails on one side. It attempts mode writes with only the global enable missing, or with only the agent bit missing. A design that checks a single enable would then accept a write it should drop. It rewrites an agent mid-transition, which exposes a design that completes the first code or keeps the old countdown. It probes the RAM ready bit at edges 63 and 64. It pulses the reset request over pending transitions, which catches a design that lets a cancelled change land late. Random mode and enable patterns from a fixed seed are checked against a bench-side model.

// File: rtl/agent_mode_ctrl.sv
module agent_mode_ctrl #(
  parameter int NUM_AGENTS = 4,
  parameter int ADDR_W     = 8,
  parameter int MODE_LAT   = 8,
  parameter int INIT_LAT   = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rd_data,
  output logic [NUM_AGENTS-1:0]   agent_clk_en,
  output logic [2*NUM_AGENTS-1:0] agent_mode
);
  localparam int CW = $clog2(MODE_LAT + 1);
  localparam int IW = $clog2(INIT_LAT + 1);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CEN  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CDIS = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_RAM  = ADDR_W'(8'h0C);
  localparam int AGENT_BASE = 16;

  logic                  rst_req;
  logic                  clk_glob;
  logic [NUM_AGENTS-1:0] clk_agent;
  logic                  ram_rdy;
  logic [IW-1:0]         ram_cnt;
  logic [NUM_AGENTS-1:0][1:0]    req_q, stat_q;
  logic [NUM_AGENTS-1:0][CW-1:0] cnt_q;
  logic [NUM_AGENTS-1:0] ctrl_hit, stat_hit;

  assign agent_clk_en = clk_glob ? clk_agent : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req   <= 1'b0;
      clk_glob  <= 1'b0;
      clk_agent <= '0;
      ram_rdy   <= 1'b0;
      ram_cnt   <= '0;
    end else begin
      if (wr_en && addr == A_RST) rst_req <= wdata[0];
      if (wr_en && addr == A_CEN) begin
        clk_glob  <= wdata[16];
        clk_agent <= wdata[NUM_AGENTS-1:0];
      end else if (wr_en && addr == A_CDIS) begin
        clk_agent <= clk_agent & ~wdata[NUM_AGENTS-1:0];
      end
      if (wr_en && addr == A_RAM && wdata[0]) begin
        ram_rdy <= 1'b0;
        ram_cnt <= IW'(INIT_LAT);
      end else if (ram_cnt == IW'(1)) begin
        ram_rdy <= 1'b1;
        ram_cnt <= '0;
      end else if (ram_cnt != '0) begin
        ram_cnt <= ram_cnt - 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
    assign ctrl_hit[i] = addr == ADDR_W'(AGENT_BASE + 8 * i);
    assign stat_hit[i] = addr == ADDR_W'(AGENT_BASE + 8 * i + 4);
    assign agent_mode[2*i +: 2] = stat_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[i]  <= 2'd0;
        stat_q[i] <= 2'd0;
        cnt_q[i]  <= '0;
      end else if (rst_req) begin
        req_q[i]  <= 2'd0;
        stat_q[i] <= 2'd0;
        cnt_q[i]  <= '0;
      end else if (wr_en && ctrl_hit[i] && agent_clk_en[i]) begin
        req_q[i] <= wdata[1:0];
        cnt_q[i] <= CW'(MODE_LAT);
      end else if (cnt_q[i] == CW'(1)) begin
        stat_q[i] <= req_q[i];
        cnt_q[i]  <= '0;
      end else if (cnt_q[i] != '0) begin
        cnt_q[i] <= cnt_q[i] - 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == A_RST) rd_data[0] = rst_req;
    if (addr == A_CEN) begin
      rd_data[16] = clk_glob;
      rd_data[NUM_AGENTS-1:0] = clk_agent;
    end
    if (addr == A_RAM) rd_data[1] = ram_rdy;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      if (ctrl_hit[i]) rd_data[1:0] = req_q[i];
      if (stat_hit[i]) rd_data[1:0] = stat_q[i];
    end
  end
endmodule

// File: rtl/agent_mode_ctrl_chk.sv
module agent_mode_ctrl_chk #(
  parameter int NUM_AGENTS = 4,
  parameter int ADDR_W     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             wdata,
  input logic [31:0]             rd_data,
  input logic [NUM_AGENTS-1:0]   agent_clk_en,
  input logic [2*NUM_AGENTS-1:0] agent_mode,
  input logic                    rst_req,
  input logic                    clk_glob,
  input logic                    ram_rdy
);
  logic mapped;
  assign mapped = (addr < ADDR_W'(16) && addr[1:0] == 2'b00) ||
                  (addr >= ADDR_W'(16) && addr < ADDR_W'(16 + 8 * NUM_AGENTS) && addr[1:0] == 2'b00);

  // R6
  ram_trig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(12) && wdata[0]) |=> !ram_rdy);

  // R7
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> agent_mode == '0);

  // R3
  clk_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_glob |-> agent_clk_en == '0);

  // R4
  clk_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8)) |=> (agent_clk_en & $past(wdata[NUM_AGENTS-1:0])) == '0);

  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> rd_data == '0);
endmodule

bind agent_mode_ctrl agent_mode_ctrl_chk #(.NUM_AGENTS(NUM_AGENTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rd_data(rd_data), .agent_clk_en(agent_clk_en), .agent_mode(agent_mode),
  .rst_req(rst_req), .clk_glob(clk_glob), .ram_rdy(ram_rdy)
);

// File: tb/agent_mode_ctrl_bench.sv
module agent_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [N-1:0] agent_clk_en;
  logic [2*N-1:0] agent_mode;
  int checks = 0, fails = 0;
  logic [1:0] exp_mode [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  agent_mode_ctrl #(.NUM_AGENTS(N), .ADDR_W(AW)) u_agent_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .agent_clk_en(agent_clk_en), .agent_mode(agent_mode));

  function automatic logic [AW-1:0] ctrl_a(int i); return AW'(16 + 8 * i); endfunction
  function automatic logic [AW-1:0] stat_a(int i); return AW'(20 + 8 * i); endfunction
  function automatic logic [N-1:0] eff_en(logic g, logic [N-1:0] a); return g ? a : '0; endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic chk_all_modes(string tag);
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin
      rd(stat_a(i), d);
      check(d == {30'd0, exp_mode[i]} && agent_mode[2*i +: 2] == exp_mode[i],
            tag, {agent_mode[2*i +: 2], d[29:0]}, {exp_mode[i], 28'd0, exp_mode[i]});
    end
  endtask

  task automatic wait_edges(int n); repeat (n) @(negedge clk); endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) exp_mode[i] = 2'd0;
    wait_edges(3); rst_n = 1'b1; wait_edges(1);

    // R1 reset state
    for (int a = 0; a < 48; a += 4) begin
      rd(AW'(a), d);
      check(d == 0, "R1 reset read", d, 0);
    end
    check(agent_clk_en == 0 && agent_mode == 0, "R1 outputs", {agent_clk_en, agent_mode}, 0);

    // R3 global off, agent bits on
    wr(8'h04, 32'h0000_000F);
    check(agent_clk_en == 0, "R3 global gate", agent_clk_en, 0);
    // R5 write ignored with global off
    wr(ctrl_a(1), 32'd3); wait_edges(9);
    rd(ctrl_a(1), d); check(d == 0, "R5 ctrl readback", d, 0);
    chk_all_modes("R5 global off");
    // R3 both set
    wr(8'h04, 32'h0001_0005);
    check(agent_clk_en == 4'b0101, "R3 enable", agent_clk_en, 4'b0101);
    rd(8'h04, d); check(d == 32'h0001_0005, "R3 readback", d, 32'h0001_0005);
    // R5 agent bit missing
    wr(ctrl_a(1), 32'd2); wait_edges(9);
    chk_all_modes("R5 agent off");

    // R2 latency edges 7 and 8
    wr(ctrl_a(0), 32'd2);
    rd(ctrl_a(0), d); check(d == 2, "R2 ctrl readback", d, 2);
    wait_edges(7); chk_all_modes("R2 before latency");
    wait_edges(1); exp_mode[0] = 2'd2; chk_all_modes("R2 at latency");

    // R9 rewrite mid-transition
    wr(ctrl_a(2), 32'd1); wait_edges(4);
    wr(ctrl_a(2), 32'd3); wait_edges(7);
    chk_all_modes("R9 restart before");
    wait_edges(1); exp_mode[2] = 2'd3; chk_all_modes("R9 new code");

    // R4 clock disable
    wr(8'h08, 32'h0000_0004);
    check(agent_clk_en == 4'b0001, "R4 clear bit", agent_clk_en, 4'b0001);
    rd(8'h08, d); check(d == 0, "R4 reads zero", d, 0);
    rd(8'h04, d); check(d == 32'h0001_0001, "R4 others kept", d, 32'h0001_0001);

    // R6 RAM init
    wr(8'h0C, 32'd1); wait_edges(63);
    rd(8'h0C, d); check(d == 0, "R6 not ready at 63", d, 0);
    wait_edges(1); rd(8'h0C, d); check(d == 2, "R6 ready at 64", d, 2);
    wr(8'h0C, 32'd1); rd(8'h0C, d); check(d == 0, "R6 retrigger clears", d, 0);

    // R8 unmapped writes
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h05, 32'hFFFF_FFFF); wr(8'hF0, 32'hFFFF_FFFF);
    rd(8'h30, d); check(d == 0, "R8 unmapped read", d, 0);
    rd(8'h04, d); check(d == 32'h0001_0001, "R8 no side effect", d, 32'h0001_0001);
    chk_all_modes("R8 modes kept");

    // random patterns (R2 R3 R5)
    for (int it = 0; it < 40; it++) begin
      int ag; logic [1:0] m; logic g; logic [N-1:0] en;
      ag = int'($urandom_range(N - 1)); m = 2'($urandom());
      g = ($urandom_range(3) != 0); en = N'($urandom());
      wr(8'h04, {15'd0, g, 12'd0, en});
      check(agent_clk_en == eff_en(g, en), "R3 random enable", agent_clk_en, eff_en(g, en));
      wr(ctrl_a(ag), {30'd0, m});
      wait_edges(7); chk_all_modes("R2 random before");
      wait_edges(1);
      if (eff_en(g, en)[ag]) exp_mode[ag] = m;
      chk_all_modes("R5 random result");
    end

    // R7 reset request over a pending change
    wr(8'h04, 32'h0001_000F);
    wr(ctrl_a(3), 32'd1); wait_edges(9); exp_mode[3] = 2'd1;
    wr(ctrl_a(0), 32'd3); wait_edges(2);
    wr(8'h00, 32'd1);
    wr(ctrl_a(1), 32'd2); wait_edges(1);
    for (int i = 0; i < N; i++) exp_mode[i] = 2'd0;
    chk_all_modes("R7 held");
    wr(8'h00, 32'd0); wait_edges(10);
    chk_all_modes("R7 after release");
    rd(ctrl_a(1), d); check(d == 0, "R7 write ignored", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule